// File: doc/BRIEF.md
# Prioritised Deduplicating Report Serialiser

This block takes result records from two on-chip checkers, one watching an adder and one watching a counter, and turns them into lines of text on a single serial output pin. Each record carries a source identity and a `REC_W`-bit value. The adder checker always wins when both offer a record in the same cycle. A checker that runs on a slow effective clock holds the same record for many fast cycles. The block therefore accepts those copies and throws them away, so that each distinct record is printed only once.

An accepted record is expanded into ASCII characters: one hex digit for the source, a space, the value as hex digits, then carriage return and line feed. The characters are queued in a small character FIFO and sent by an 8N1 transmitter. The transmitter is paced by a one-cycle enable pulse that fires `BAUD_DIV` cycles apart, which is 16 times the baud rate. `BAUD_DIV` is the clock frequency divided by 16 times the baud rate, for example 651 for 9600 baud from a 100 MHz clock.

Both record inputs are valid/ready. A record moves on a cycle where valid and ready are both high. The producer holds valid and data steady until that cycle. Ready depends on the FIFO fill, on suspend and, for the counter input, on the adder's valid. Ready is never high unless the whole record fits in the FIFO, so a record is never split. Two plain control inputs are provided. The first forces the current record to print even if it is a repeat. The second, suspend, closes the adder input so that counter records can drain.

Top module: `rpt_serializer`

## Requirements
- R1: When both inputs are valid and suspend is low, the adder record is taken first, and `cnt_ready` stays low while `add_valid` is high.
- R2: A record whose source and value equal the last printed record is accepted and discarded without output, however many cycles it stays offered.
- R3: A printed line is, in order: the source digit (`0` for the adder, `1` for the counter), 0x20, the value as `REC_W/4` hex digits with the most significant first, 0x0D, and 0x0A. Hex digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46.
- R4: Each character is sent as one low start bit, eight data bits with the LSB first, and one high stop bit. The line rests high when idle.
- R5: Every bit lasts 16 enable pulses spaced `BAUD_DIV` cycles apart, and characters of one line follow each other with no extra gap, so consecutive start edges are 160·`BAUD_DIV` cycles apart (±`BAUD_DIV`).
- R6: While `force_report` is high, a record is printed even when it repeats the last printed record.
- R7: While `suspend` is high, `add_ready` is low and no adder record is taken. Counter records are still served.
- R8: On a falling edge of `suspend`, the last-printed memory is cleared, so the next record prints even if it equals the one printed before.
- R9: A record is taken only when the expander is idle and the FIFO has room for the whole line. Otherwise ready stays low, and the pending record is printed whole once room appears.
- R10: During and after reset, with no record offered, `txd` is high and no character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| add_valid | input | 1 | adder record offered |
| add_data | input | REC_W | adder record value |
| add_ready | output | 1 | adder record taken this cycle when valid |
| cnt_valid | input | 1 | counter record offered |
| cnt_data | input | REC_W | counter record value |
| cnt_ready | output | 1 | counter record taken this cycle when valid |
| force_report | input | 1 | print the taken record even if it is a repeat |
| suspend | input | 1 | close the adder input; falling edge clears repeat memory |
| txd | output | 1 | serial output, 8N1, idle high |

## Verification
The bench builds the block with `REC_W` = 8, `FIFO_DEPTH` = 8 and `BAUD_DIV` = 2. A line is then six characters and a bit lasts 32 cycles, so a whole line leaves the pin in under 2000 cycles and many records fit in the run. With only eight FIFO slots, a second six-character line cannot be taken until the first has mostly drained. This puts the whole-line back-pressure rule in reach of every back-to-back offer. It also lets the bench time consecutive start edges against the exact 320-cycle character frame.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  typedef enum logic {SRC_ADDER = 1'b0, SRC_COUNTER = 1'b1} src_e;

  localparam logic [7:0] CH_SPACE = 8'h20;
  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;

  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction
endpackage

// File: rtl/rpt_select.sv
module rpt_select
  import rpt_pkg::*;
#(
  parameter int REC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_valid,
  input  logic [REC_W-1:0] add_data,
  output logic             add_ready,
  input  logic             cnt_valid,
  input  logic [REC_W-1:0] cnt_data,
  output logic             cnt_ready,
  input  logic             force_report,
  input  logic             suspend,
  input  logic             take_ok,
  output logic             emit_valid,
  output src_e             emit_src,
  output logic [REC_W-1:0] emit_data
);
  logic             suspend_q;
  logic             last_vld;
  src_e             last_src;
  logic [REC_W-1:0] last_data;
  logic             pick_add, any_valid, is_repeat;

  always_comb begin
    pick_add  = add_valid && !suspend;
    any_valid = pick_add || cnt_valid;
    add_ready = take_ok && !suspend;
    cnt_ready = take_ok && !pick_add;
    emit_src  = pick_add ? SRC_ADDER : SRC_COUNTER;
    emit_data = pick_add ? add_data : cnt_data;
    is_repeat = last_vld && (last_src == emit_src) && (last_data == emit_data);
    emit_valid = take_ok && any_valid && (!is_repeat || force_report);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      suspend_q <= 1'b0;
      last_vld  <= 1'b0;
      last_src  <= SRC_ADDER;
      last_data <= '0;
    end else begin
      suspend_q <= suspend;
      if (suspend_q && !suspend) last_vld <= 1'b0;
      if (emit_valid) begin
        last_vld  <= 1'b1;
        last_src  <= emit_src;
        last_data <= emit_data;
      end
    end
  end

  AST_ADDER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (add_valid && !suspend && emit_valid) |-> emit_src == SRC_ADDER); // R1
  AST_SUSPEND_COUNTER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend && emit_valid) |-> emit_src == SRC_COUNTER); // R7
endmodule

// File: rtl/rpt_expand.sv
module rpt_expand
  import rpt_pkg::*;
#(
  parameter int REC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  src_e             load_src,
  input  logic [REC_W-1:0] load_data,
  output logic             busy,
  output logic             out_valid,
  output logic [7:0]       out_char,
  input  logic             out_ready
);
  localparam int ND  = REC_W / 4;
  localparam int NCH = ND + 4;
  localparam int IW  = $clog2(NCH);

  logic [IW-1:0]    idx;
  src_e             src_q;
  logic [REC_W-1:0] data_q;
  logic [REC_W-1:0] shifted;

  always_comb begin
    out_valid = busy;
    shifted   = '0;
    if (idx == '0) begin
      out_char = hex_char({3'b000, src_q});
    end else if (idx == IW'(1)) begin
      out_char = CH_SPACE;
    end else if (idx == IW'(NCH - 2)) begin
      out_char = CH_CR;
    end else if (idx == IW'(NCH - 1)) begin
      out_char = CH_LF;
    end else begin
      shifted  = data_q >> (4 * (ND + 1 - int'(idx)));
      out_char = hex_char(shifted[3:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      src_q  <= SRC_ADDER;
      data_q <= '0;
    end else if (!busy) begin
      if (load) begin
        busy   <= 1'b1;
        idx    <= '0;
        src_q  <= load_src;
        data_q <= load_data;
      end
    end else if (out_ready) begin
      if (idx == IW'(NCH - 1)) busy <= 1'b0;
      else                     idx  <= idx + 1'b1;
    end
  end

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R9
endmodule

// File: rtl/rpt_fifo.sv
module rpt_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [DW-1:0]              wr_data,
  output logic                       wr_ready,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  input  logic                       rd_ready,
  output logic [$clog2(DEPTH+1)-1:0] space
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  always_comb begin
    wr_ready = count < CW'(DEPTH);
    rd_valid = count != '0;
    rd_data  = mem[rp];
    space    = CW'(DEPTH) - count;
    do_wr    = wr_valid && wr_ready;
    do_rd    = rd_valid && rd_ready;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_wr) - CW'(do_rd);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R9
endmodule

// File: rtl/rpt_uart_tx.sv
module rpt_uart_tx #(
  parameter int BAUD_DIV = 651
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       txd
);
  localparam int DW = $clog2(BAUD_DIV + 1);

  logic [DW-1:0] div_cnt;
  logic          tick;
  logic          busy;
  logic [3:0]    sub;
  logic [3:0]    bitn;
  logic [9:0]    shreg;

  assign tick     = div_cnt == DW'(BAUD_DIV - 1);
  assign in_ready = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sub   <= '0;
      bitn  <= '0;
      shreg <= '1;
      txd   <= 1'b1;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        sub   <= '0;
        bitn  <= '0;
        shreg <= {1'b1, in_data, 1'b0};
        txd   <= 1'b0;
      end
    end else if (tick) begin
      if (sub == 4'd15) begin
        sub <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          bitn  <= bitn + 1'b1;
          shreg <= {1'b1, shreg[9:1]};
          txd   <= shreg[1];
        end
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R4
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd)); // R5
endmodule

// File: rtl/rpt_serializer.sv
module rpt_serializer
  import rpt_pkg::*;
#(
  parameter int REC_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int BAUD_DIV   = 651
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_valid,
  input  logic [REC_W-1:0] add_data,
  output logic             add_ready,
  input  logic             cnt_valid,
  input  logic [REC_W-1:0] cnt_data,
  output logic             cnt_ready,
  input  logic             force_report,
  input  logic             suspend,
  output logic             txd
);
  localparam int NCH = REC_W / 4 + 4;
  localparam int SW  = $clog2(FIFO_DEPTH + 1);

  logic             take_ok, emit_valid, exp_busy;
  src_e             emit_src;
  logic [REC_W-1:0] emit_data;
  logic             ch_valid, ch_ready, q_valid, q_ready;
  logic [7:0]       ch_data, q_data;
  logic [SW-1:0]    space;

  assign take_ok = !exp_busy && (space >= SW'(NCH));

  rpt_select #(.REC_W(REC_W)) u_select (
    .clk, .rst_n, .add_valid, .add_data, .add_ready,
    .cnt_valid, .cnt_data, .cnt_ready, .force_report, .suspend,
    .take_ok, .emit_valid, .emit_src, .emit_data
  );

  rpt_expand #(.REC_W(REC_W)) u_expand (
    .clk, .rst_n, .load(emit_valid), .load_src(emit_src), .load_data(emit_data),
    .busy(exp_busy), .out_valid(ch_valid), .out_char(ch_data), .out_ready(ch_ready)
  );

  rpt_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk, .rst_n, .wr_valid(ch_valid), .wr_data(ch_data), .wr_ready(ch_ready),
    .rd_valid(q_valid), .rd_data(q_data), .rd_ready(q_ready), .space
  );

  rpt_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
    .clk, .rst_n, .in_valid(q_valid), .in_data(q_data), .in_ready(q_ready), .txd
  );

  AST_LOAD_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |-> space >= SW'(NCH)); // R9
endmodule

// File: tb/rpt_serializer_tb.sv
module rpt_serializer_tb_top;
  localparam int W = 8, DIV = 2, BIT = 16 * DIV, HALF = 8 * DIV, NCH = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic add_valid = 0, cnt_valid = 0, force_report = 0, suspend = 0;
  logic [W-1:0] add_data = '0, cnt_data = '0;
  logic add_ready, cnt_ready, txd;
  int n_chk = 0, n_fail = 0, cyc = 0, rx_cnt = 0, frame_err = 0;
  logic [7:0] rx_buf [0:511];
  int rx_t [0:511];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rpt_serializer #(.REC_W(W), .FIFO_DEPTH(8), .BAUD_DIV(DIV)) dut_i (
    .clk, .rst_n, .add_valid, .add_data, .add_ready, .cnt_valid, .cnt_data,
    .cnt_ready, .force_report, .suspend, .txd);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  // serial receiver: samples mid-bit
  initial begin
    logic [7:0] b;
    wait (rst_n);
    forever begin
      @(negedge txd);
      rx_t[rx_cnt] = cyc;
      repeat (HALF) @(posedge clk);
      if (txd !== 1'b0) frame_err++;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(posedge clk);
        b[i] = txd;
      end
      repeat (BIT) @(posedge clk);
      if (txd !== 1'b1) frame_err++;
      rx_buf[rx_cnt] = b;
      rx_cnt++;
    end
  end

  function automatic logic [7:0] hexc(input logic [3:0] n);
    return (n < 10) ? 8'h30 + n : 8'h41 + (n - 10);
  endfunction

  task automatic expect_rec(input int base, input bit src, input logic [7:0] v, input string req);
    logic [7:0] e [NCH];
    int bad = -1;
    e[0] = src ? 8'h31 : 8'h30; e[1] = 8'h20; e[2] = hexc(v[7:4]);
    e[3] = hexc(v[3:0]); e[4] = 8'h0D; e[5] = 8'h0A;
    for (int i = 0; i < NCH; i++) if (bad < 0 && rx_buf[base + i] !== e[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, rx_buf[base + bad], e[bad]);
  endtask

  task automatic wait_rx(input int n);
    int g = 0;
    while (rx_cnt < n && g < 30000) begin @(posedge clk); g++; end
    if (rx_cnt < n) chk(0, "wait_rx", rx_cnt, n);
  endtask

  task automatic offer(input logic av, input logic [7:0] ad, input logic cv, input logic [7:0] cd);
    logic pa, pc, fa, fc;
    int g = 0;
    pa = av; pc = cv;
    @(negedge clk);
    add_valid = av; add_data = ad; cnt_valid = cv; cnt_data = cd;
    while ((pa || pc) && g < 30000) begin
      #1;
      fa = pa && add_ready; fc = pc && cnt_ready;
      if (pa && cnt_valid && !suspend && cnt_ready) chk(0, "R1 cnt_ready while adder valid", 1, 0);
      @(posedge clk); #1;
      if (fa) begin pa = 0; add_valid = 0; end
      if (fc) begin pc = 0; cnt_valid = 0; end
      g++;
    end
  endtask

  typedef struct packed {
    logic av; logic [7:0] ad; logic cv; logic [7:0] cd;
    logic [1:0] n; logic s0; logic [7:0] d0; logic s1; logic [7:0] d1;
  } vec_t;

  // R1 priority, R2 repeat drop, R3 line format
  localparam vec_t VEC [8] = '{
    '{1'b1, 8'h3C, 1'b0, 8'h00, 2'd1, 1'b0, 8'h3C, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'h5A, 2'd1, 1'b1, 8'h5A, 1'b0, 8'h00},
    '{1'b1, 8'h11, 1'b1, 8'h22, 2'd2, 1'b0, 8'h11, 1'b1, 8'h22},
    '{1'b0, 8'h00, 1'b1, 8'h22, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b1, 8'h22, 1'b0, 8'h00, 2'd1, 1'b0, 8'h22, 1'b0, 8'h00},
    '{1'b1, 8'hF0, 1'b0, 8'h00, 2'd1, 1'b0, 8'hF0, 1'b0, 8'h00},
    '{1'b1, 8'hF0, 1'b0, 8'h00, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00},
    '{1'b0, 8'h00, 1'b1, 8'hF0, 2'd1, 1'b1, 8'hF0, 1'b0, 8'h00}
  };

  initial begin
    int base, seen;
    repeat (5) @(posedge clk);
    #1 chk(txd === 1'b1, "R10 txd in reset", txd, 1);
    @(negedge clk) rst_n = 1'b1;
    repeat (200) @(posedge clk);
    #1 chk(txd === 1'b1 && rx_cnt == 0, "R10 idle after reset", rx_cnt, 0);

    foreach (VEC[k]) begin
      base = rx_cnt;
      offer(VEC[k].av, VEC[k].ad, VEC[k].cv, VEC[k].cd);
      if (VEC[k].n == 0) begin
        repeat (2500) @(posedge clk);
        chk(rx_cnt == base, "R2 repeat suppressed", rx_cnt - base, 0);
      end else begin
        wait_rx(base + NCH * VEC[k].n);
        expect_rec(base, VEC[k].s0, VEC[k].d0, "R3 R1 table line");
        if (VEC[k].n == 2) begin
          wait_rx(base + 2 * NCH);
          expect_rec(base + NCH, VEC[k].s1, VEC[k].d1, "R1 second line");
        end
      end
    end
    chk(frame_err == 0, "R4 start/stop framing", frame_err, 0);
    chk(rx_t[1] - rx_t[0] >= 160 * DIV - DIV && rx_t[1] - rx_t[0] <= 160 * DIV + DIV,
        "R5 char spacing", rx_t[1] - rx_t[0], 160 * DIV);

    // R6: forced repeat of counter F0
    base = rx_cnt;
    force_report = 1;
    offer(0, 0, 1, 8'hF0);
    force_report = 0;
    wait_rx(base + NCH);
    expect_rec(base, 1, 8'hF0, "R6 forced repeat");

    // R2: record held for many cycles prints once
    base = rx_cnt;
    @(negedge clk) begin add_valid = 1; add_data = 8'h6B; end
    repeat (3000) @(posedge clk);
    @(negedge clk) add_valid = 0;
    repeat (2500) @(posedge clk);
    chk(rx_cnt == base + NCH, "R2 held record once", rx_cnt - base, NCH);
    expect_rec(base, 0, 8'h6B, "R2 held record line");

    // R9: second line waits for whole-line room
    base = rx_cnt;
    offer(1, 8'h01, 0, 0);
    @(negedge clk) begin add_valid = 1; add_data = 8'h02; end
    repeat (40) @(negedge clk);
    #1 chk(add_ready == 0, "R9 ready low without room", add_ready, 0);
    offer(1, 8'h02, 0, 0);
    wait_rx(base + 2 * NCH);
    expect_rec(base, 0, 8'h01, "R9 first line");
    expect_rec(base + NCH, 0, 8'h02, "R9 second line whole");

    // R7: suspend closes adder input, counter drains
    base = rx_cnt; seen = 0;
    @(negedge clk) begin suspend = 1; add_valid = 1; add_data = 8'h77; cnt_valid = 1; cnt_data = 8'h88; end
    for (int i = 0; i < 3000; i++) begin
      logic fc;
      #1; if (add_ready) seen++;
      fc = cnt_valid && cnt_ready;
      @(posedge clk); #1;
      if (fc) cnt_valid = 0;
    end
    chk(seen == 0, "R7 add_ready low in suspend", seen, 0);
    chk(rx_cnt == base + NCH, "R7 only counter line", rx_cnt - base, NCH);
    expect_rec(base, 1, 8'h88, "R7 counter served");
    @(negedge clk) suspend = 0;
    offer(1, 8'h77, 0, 0);
    wait_rx(base + 2 * NCH);
    expect_rec(base + NCH, 0, 8'h77, "R7 adder after release");

    // R8: suspend release clears repeat memory
    base = rx_cnt;
    offer(0, 0, 1, 8'h99);
    wait_rx(base + NCH);
    @(negedge clk) suspend = 1;
    repeat (5) @(negedge clk);
    suspend = 0;
    offer(0, 0, 1, 8'h99);
    wait_rx(base + 2 * NCH);
    expect_rec(base + NCH, 1, 8'h99, "R8 repeat after suspend release");
    chk(frame_err == 0, "R4 framing overall", frame_err, 0);
    finish_run();
  end
endmodule